// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous-strobe DRAM interface. The row strobe, column strobe, write strobe and the 12-bit multiplexed address are sampled on the system clock. Every period in which the row strobe is low is classified into exactly one cycle type. The decision rests only on the order in which the strobe edges arrive, and on how long the row strobe stays low. When the row strobe returns high, the block reports the type as a one-clock pulse carrying a 3-bit code.

The block also handles refresh. It keeps a 12-bit refresh row counter that steps on each counter-based refresh, and it reports which row is being refreshed. It drives an output enable for the data pin. A level flag stays high for as long as the device is in self refresh. The memory array is not part of this block.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `cycValid`, `dataOe` and `selfRef` are low, `refRow` is 0 and the refresh counter holds 0.
- R2: A row-strobe period that starts with the column strobe high, and whose first column-strobe fall sees the write strobe high, is reported as read (code 1). `dataOe` goes high one clock after that column-strobe fall.
- R3: When the write strobe is already low at the first column-strobe fall, the period is reported as early write (code 2). `dataOe` stays low for the whole period.
- R4: When the write strobe falls after the column strobe has fallen, the period is reported as read-modify-write (code 3). `dataOe` stays high after the write-strobe fall.
- R5: `dataOe` is low one clock after the column strobe is seen high.
- R6: A period that starts with the column strobe high and has no column-strobe fall before the row strobe rises is reported as row-only refresh (code 4). `refRow` equals the address sampled at the row-strobe fall; later address changes are ignored.
- R7: A period that starts with the column strobe low and the write strobe high is reported as counter refresh (code 5). `refRow` equals the counter value, the address is ignored, and the counter then increments.
- R8: A period that starts with both the column and write strobes low is reported as test-mode entry (code 0). The counter does not move.
- R9: If the column strobe stays low from an access across the row-strobe rise and into a new row-strobe fall, that new period is reported as hidden refresh (code 6). It uses and increments the counter, and `dataOe` stays high throughout.
- R10: A counter refresh whose row strobe stays low for `SelfCycles` clocks enters self refresh. `selfRef` rises exactly `SelfCycles` clocks after the row-strobe fall is sampled.
- R11: On entering self refresh, one counter refresh is reported on `refRow` and the counter increments. A further increment follows every `RefreshInterval` clocks. The rising row strobe ends self refresh with code 7, and `selfRef` drops at the same time.
- R12: The refresh counter wraps from 4095 to 0.
- R13: `cycValid` is high for exactly one clock, one clock after the row-strobe rise is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| addr | input | 12 | Multiplexed row/column address |
| cycValid | output | 1 | One-clock pulse: a cycle type is reported |
| cycCode | output | 3 | Cycle type code, valid with cycValid |
| refRow | output | 12 | Row refreshed by the latest refresh |
| dataOe | output | 1 | Output enable for the data pin |
| selfRef | output | 1 | High while in self refresh |

## Verification
The directed scenarios target the edge orderings that separate neighbouring cycle types.

- The write strobe is dropped just before the column strobe and again just after it. A decoder that ignores this order reports the wrong code between early write and read-modify-write, or drives the data pin during a write.
- The column strobe is held low across a row-strobe rise. A decoder that loses this history reports an ordinary counter refresh instead of a hidden refresh, or drops the output enable while the read data must remain driven.
- The self-refresh threshold is probed one clock before and at the exact entry cycle, and the stay is long enough for two timer steps. The count of rows refreshed is then read back through a later counter refresh, which exposes an off-by-one in either timer.
- The address is changed after the row-strobe fall in row-only and counter refreshes, so latching the wrong sample or reading the pins is visible.
- The counter is run to 4095 and one step further to check the wrap.

// File: rtl/dram_cycle_pkg.sv
package dram_cycle_pkg;

  typedef enum logic [2:0] {
    CODE_TEST   = 3'd0,
    CODE_READ   = 3'd1,
    CODE_EWRITE = 3'd2,
    CODE_RMW    = 3'd3,
    CODE_RONLY  = 3'd4,
    CODE_CBR    = 3'd5,
    CODE_HIDDEN = 3'd6,
    CODE_SELF   = 3'd7
  } cycCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CBR,
    ST_SELF,
    ST_TEST,
    ST_HID
  } decState_e;

  // Commands from the control FSM to the row datapath
  typedef struct packed {
    logic latchRow;   // capture address as external row
    logic reportExt;  // publish latched external row
    logic reportCnt;  // publish counter row and step counter
  } rowCmd_t;

endpackage

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_cycle_pkg::*;
#(
  parameter int SelfCycles      = 5000,
  parameter int RefreshInterval = 500
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  output rowCmd_t             rowCmd,
  output logic                cycValid,
  output logic [2:0]          cycCode,
  output logic                dataOe,
  output logic                selfRef
);

  localparam int LowW  = $clog2(SelfCycles + 1);
  localparam int TickW = $clog2(RefreshInterval + 1);

  decState_e state, stateD;
  logic prevRas, prevCas, prevWe;
  logic wEarly, wEarlyD, rmwSeen, rmwSeenD, casHeld, casHeldD;
  logic [LowW-1:0]  lowCnt, lowCntD;
  logic [TickW-1:0] tickCnt, tickCntD;
  logic cycValidD, dataOeD, selfRefD;
  logic [2:0] cycCodeD;

  logic rasFall, rasRise, casFall, weFall;
  assign rasFall = prevRas & ~rasN;
  assign rasRise = ~prevRas & rasN;
  assign casFall = prevCas & ~casN;
  assign weFall  = prevWe & ~weN;

  always_comb begin
    stateD    = state;
    wEarlyD   = wEarly;
    rmwSeenD  = rmwSeen;
    casHeldD  = casHeld;
    lowCntD   = lowCnt;
    tickCntD  = tickCnt;
    selfRefD  = selfRef;
    cycValidD = 1'b0;
    cycCodeD  = cycCode;
    rowCmd    = '0;

    unique case (state)
      ST_IDLE: if (rasFall) begin
        if (casN) begin
          stateD          = ST_ROW;
          rowCmd.latchRow = 1'b1;
        end else if (casHeld) begin
          stateD = ST_HID;
        end else if (!weN) begin
          stateD = ST_TEST;
        end else begin
          stateD  = ST_CBR;
          lowCntD = '0;
        end
      end
      ST_ROW: if (rasRise) begin
        stateD           = ST_IDLE;
        cycValidD        = 1'b1;
        cycCodeD         = CODE_RONLY;
        rowCmd.reportExt = 1'b1;
      end else if (casFall) begin
        stateD   = ST_COL;
        wEarlyD  = ~weN;
        rmwSeenD = 1'b0;
      end
      ST_COL: if (rasRise) begin
        stateD    = ST_IDLE;
        cycValidD = 1'b1;
        cycCodeD  = wEarly ? CODE_EWRITE : (rmwSeen ? CODE_RMW : CODE_READ);
        if (!casN) casHeldD = 1'b1;
      end else if (weFall && !casN && !wEarly) begin
        rmwSeenD = 1'b1;
      end
      ST_CBR: if (rasRise) begin
        stateD           = ST_IDLE;
        cycValidD        = 1'b1;
        cycCodeD         = CODE_CBR;
        rowCmd.reportCnt = 1'b1;
      end else if (lowCnt == LowW'(SelfCycles - 1)) begin
        stateD           = ST_SELF;
        selfRefD         = 1'b1;
        tickCntD         = '0;
        rowCmd.reportCnt = 1'b1;
      end else begin
        lowCntD = lowCnt + 1'b1;
      end
      ST_SELF: if (rasRise) begin
        stateD    = ST_IDLE;
        cycValidD = 1'b1;
        cycCodeD  = CODE_SELF;
        selfRefD  = 1'b0;
      end else if (tickCnt == TickW'(RefreshInterval - 1)) begin
        tickCntD         = '0;
        rowCmd.reportCnt = 1'b1;
      end else begin
        tickCntD = tickCnt + 1'b1;
      end
      ST_TEST: if (rasRise) begin
        stateD    = ST_IDLE;
        cycValidD = 1'b1;
        cycCodeD  = CODE_TEST;
      end
      ST_HID: if (rasRise) begin
        stateD           = ST_IDLE;
        cycValidD        = 1'b1;
        cycCodeD         = CODE_HIDDEN;
        rowCmd.reportCnt = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase

    if (casN) casHeldD = 1'b0;

    dataOeD = dataOe;
    if (casN) dataOeD = 1'b0;
    else if (casFall && !rasN && (state == ST_ROW || state == ST_COL)) dataOeD = weN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      prevRas  <= 1'b1;
      prevCas  <= 1'b1;
      prevWe   <= 1'b1;
      wEarly   <= 1'b0;
      rmwSeen  <= 1'b0;
      casHeld  <= 1'b0;
      lowCnt   <= '0;
      tickCnt  <= '0;
      cycValid <= 1'b0;
      cycCode  <= CODE_TEST;
      dataOe   <= 1'b0;
      selfRef  <= 1'b0;
    end else begin
      state    <= stateD;
      prevRas  <= rasN;
      prevCas  <= casN;
      prevWe   <= weN;
      wEarly   <= wEarlyD;
      rmwSeen  <= rmwSeenD;
      casHeld  <= casHeldD;
      lowCnt   <= lowCntD;
      tickCnt  <= tickCntD;
      cycValid <= cycValidD;
      cycCode  <= cycCodeD;
      dataOe   <= dataOeD;
      selfRef  <= selfRefD;
    end
  end

endmodule

// File: rtl/dram_row_path.sv
module dram_row_path
  import dram_cycle_pkg::*;
#(
  parameter int RowBits = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  rowCmd_t            rowCmd,
  input  logic [RowBits-1:0] addr,
  output logic [RowBits-1:0] refRow
);

  logic [RowBits-1:0] rowLatch, rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowLatch <= '0;
      rowCnt   <= '0;
      refRow   <= '0;
    end else begin
      if (rowCmd.latchRow) rowLatch <= addr;
      if (rowCmd.reportExt) refRow <= rowLatch;
      if (rowCmd.reportCnt) begin
        refRow <= rowCnt;
        rowCnt <= rowCnt + 1'b1;  // natural wrap at all ones
      end
    end
  end

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_cycle_pkg::*;
#(
  parameter int RowBits         = 12,
  parameter int SelfCycles      = 5000,
  parameter int RefreshInterval = 500
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic [RowBits-1:0] addr,
  output logic               cycValid,
  output logic [2:0]         cycCode,
  output logic [RowBits-1:0] refRow,
  output logic               dataOe,
  output logic               selfRef
);

  rowCmd_t rowCmd;

  dram_cycle_ctrl #(
    .SelfCycles     (SelfCycles),
    .RefreshInterval(RefreshInterval)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .rowCmd  (rowCmd),
    .cycValid(cycValid),
    .cycCode (cycCode),
    .dataOe  (dataOe),
    .selfRef (selfRef)
  );

  dram_row_path #(
    .RowBits(RowBits)
  ) path_i (
    .clk   (clk),
    .rstN  (rstN),
    .rowCmd(rowCmd),
    .addr  (addr),
    .refRow(refRow)
  );

endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       cycValid,
  input logic [2:0] cycCode,
  input logic       dataOe,
  input logic       selfRef
);

  // R13
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |=> !cycValid);

  // R13
  pulse_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |-> ($past(rasN) && !$past(rasN, 2)));

  // R5
  oe_off_cas_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(casN) |-> !dataOe);

  // R3
  oe_rise_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> ($past(weN) && !$past(casN)));

  // R11
  self_holds_ras_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    selfRef |-> !$past(rasN));

  // R11
  self_exit_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycCode == 3'd7) |-> $past(selfRef));

endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .rasN    (rasN),
  .casN    (casN),
  .weN     (weN),
  .cycValid(cycValid),
  .cycCode (cycCode),
  .dataOe  (dataOe),
  .selfRef (selfRef)
);

// File: tb/dram_cycle_decoder_tb_top.sv
module dram_cycle_decoder_tb_top;

  localparam int SelfCyc = 5000;
  localparam int Intv    = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [11:0] addr = '0;
  logic cycValid, dataOe, selfRef;
  logic [2:0] cycCode;
  logic [11:0] refRow;

  int checks = 0;
  int fails  = 0;
  int expCnt = 0;

  always #10 clk = ~clk;

  dram_cycle_decoder dut_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .cycValid(cycValid), .cycCode(cycCode),
    .refRow(refRow), .dataOe(dataOe), .selfRef(selfRef)
  );

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkCode(input string req, input int exp);
    chk(cycValid === 1'b1 && cycCode == 3'(exp), req, {cycValid, cycCode}, 8 + exp);
  endtask

  task automatic testReset();
    tk(1);
    chk(!cycValid && !dataOe && !selfRef && refRow == 0, "R1", {cycValid, dataOe, selfRef}, 0);
  endtask

  task automatic testRead(input logic [11:0] row);
    addr = row; rasN = 0; tk(2);
    addr = 12'h0AB; casN = 0; tk(1);
    chk(dataOe === 1'b1, "R2 oe", dataOe, 1);
    tk(1);
    casN = 1; tk(1);
    chk(dataOe === 1'b0 && !cycValid, "R5", dataOe, 0);
    rasN = 1; tk(1);
    chkCode("R2", 1);
    tk(1);
    chk(cycValid === 1'b0, "R13", cycValid, 0);
  endtask

  task automatic testEarlyWrite();
    rasN = 0; tk(1);
    weN = 0; tk(1);
    casN = 0; tk(1);
    chk(dataOe === 1'b0, "R3 oe", dataOe, 0);
    tk(2);
    chk(dataOe === 1'b0, "R3 oe hold", dataOe, 0);
    rasN = 1; casN = 1; weN = 1; tk(1);
    chkCode("R3", 2);
  endtask

  task automatic testRmw();
    rasN = 0; tk(1);
    casN = 0; tk(1);
    chk(dataOe === 1'b1, "R4 oe", dataOe, 1);
    weN = 0; tk(2);
    chk(dataOe === 1'b1, "R4 oe after W", dataOe, 1);
    rasN = 1; casN = 1; weN = 1; tk(1);
    chkCode("R4", 3);
    chk(dataOe === 1'b0, "R5 rmw", dataOe, 0);
  endtask

  task automatic testRasOnly(input logic [11:0] row);
    addr = row; rasN = 0; tk(1);
    addr = ~row; tk(3);
    rasN = 1; tk(1);
    chkCode("R6", 4);
    chk(refRow == row, "R6 row", refRow, row);
  endtask

  task automatic doCbr(input logic doCheck);
    casN = 0; tk(1);
    rasN = 0; addr = 12'h5A5; tk(3);
    rasN = 1; tk(1);
    if (doCheck) begin
      chkCode("R7", 5);
      chk(refRow == 12'(expCnt), "R7 row", refRow, expCnt);
    end
    expCnt = (expCnt + 1) % 4096;
    casN = 1; tk(1);
  endtask

  task automatic testTestMode();
    casN = 0; weN = 0; tk(1);
    rasN = 0; tk(3);
    rasN = 1; tk(1);
    chkCode("R8", 0);
    casN = 1; weN = 1; tk(1);
    doCbr(1'b1);  // R8: counter did not move
  endtask

  task automatic testHidden();
    rasN = 0; tk(1);
    casN = 0; tk(1);
    chk(dataOe === 1'b1, "R9 oe read", dataOe, 1);
    rasN = 1; tk(1);
    chkCode("R9 read", 1);
    tk(2);
    rasN = 0; tk(3);
    chk(dataOe === 1'b1, "R9 oe held", dataOe, 1);
    rasN = 1; tk(1);
    chkCode("R9", 6);
    chk(refRow == 12'(expCnt), "R9 row", refRow, expCnt);
    chk(dataOe === 1'b1, "R9 oe end", dataOe, 1);
    expCnt = (expCnt + 1) % 4096;
    casN = 1; tk(1);
    chk(dataOe === 1'b0, "R5 hidden", dataOe, 0);
  endtask

  task automatic testSelf();
    casN = 0; tk(1);
    rasN = 0; tk(SelfCyc);
    chk(selfRef === 1'b0, "R10 early", selfRef, 0);
    tk(1);
    chk(selfRef === 1'b1, "R10 entry", selfRef, 1);
    chk(refRow == 12'(expCnt), "R11 entry row", refRow, expCnt);
    tk(2 * Intv + 10);
    chk(selfRef === 1'b1, "R11 level", selfRef, 1);
    rasN = 1; tk(1);
    chkCode("R11", 7);
    chk(selfRef === 1'b0, "R11 exit", selfRef, 0);
    expCnt = (expCnt + 3) % 4096;
    casN = 1; tk(1);
    doCbr(1'b1);  // R11: three rows consumed in self refresh
  endtask

  task automatic testWrap();
    while (expCnt != 4095) doCbr(1'b0);
    doCbr(1'b1);
    chk(refRow == 12'd4095, "R12 top", refRow, 4095);
    doCbr(1'b1);
    chk(refRow == 12'd0, "R12 wrap", refRow, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    tk(3);
    rstN = 1;
    testReset();
    testRead(12'h123);
    testEarlyWrite();
    testRmw();
    testRasOnly(12'hC3F);
    doCbr(1'b1);
    testTestMode();
    testHidden();
    testSelf();
    testWrap();
    finishRun();
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule